// File: doc/BRIEF.md
# Guard-Timed Tone Digit Register

This block sits behind a dual-tone discriminator. The discriminator reports a qualified-pair flag together with the row (low-group) and column (high-group) index of the pair it hears. The block decides whether that pair lasted long enough to count as a keypress, and whether the silence that follows lasted long enough to count as a gap between keypresses. Two guard timers make these decisions. Both count a 1 ms time-base strobe, and each has its own length. A pair must be held for the full present guard before it is registered. After registration, the flag must stay low for the full absent guard before the block accepts a new pair. A gap in the flag that is shorter than the absent guard is treated as a dropout and bridged.

At registration the pair is converted to a fixed 4-bit key code. The code enters an output latch a set number of clock cycles later. A delayed-valid flag rises a few cycles after that, so the code is always stable before the flag. The delayed-valid flag falls when the absent guard expires. An inhibit input masks the fourth column. An output-enable input gates the pad driver of the code bus without disturbing the latch. A power-down input parks the timers and the flag but keeps the last code.

Top module: `tone_digit_steer`

## Requirements
- R1: A qualified pair held for fewer than PRESENT_TICKS time-base strobes is not registered: code_o, dv_o and gt_o keep their values.
- R2: A pair held continuously for PRESENT_TICKS strobes is registered on the edge where the last of those strobes is seen. With the defaults (30 strobes of 1 ms), a 40 ms tone is always accepted and a 20 ms burst is always rejected.
- R3: After registration, a low period of the qualified flag that is shorter than ABSENT_TICKS strobes is bridged. dv_o stays high and no new code is loaded, even if a different pair follows the gap.
- R4: After registration, once the flag has stayed low for ABSENT_TICKS strobes, dv_o returns to 0 on that edge and the block accepts a new pair.
- R5: The key code is computed from (row, col) over the keypad laid out as "1 2 3 A / 4 5 6 B / 7 8 9 C / * 0 # D" (row 0 at the top, col 0 at the left). The codes are: digits 1 to 9 give 0001 to 1001, 0 gives 1010, * gives 1011, # gives 1100, A gives 1101, B gives 1110, C gives 1111 and D gives 0000.
- R6: While inhibit_i is high, pairs with col_i = 3 are treated as absent. They are never registered, code_o keeps the previous code, and gt_o is low on the next cycle. Pairs in the other columns register normally.
- R7: code_o takes the new code LATCH_DLY clock cycles after the registration edge, and dv_o rises FLAG_DLY cycles after it. FLAG_DLY is larger than LATCH_DLY, so code_o is stable on the cycle where dv_o rises.
- R8: code_oe_o follows oe_i. code_o keeps the latched code while the output enable is low, and the same code is presented again when the enable returns.
- R9: gt_o is high from the registration edge for as long as the qualified flag stays high. It is low during a dropout and outside a registered digit.
- R10: While pdown_i is high, both guard timers and any pending load are cleared, and dv_o and gt_o are 0 on the next cycle. code_o does not change.
- R11: After reset, code_o = 0000, dv_o = 0 and gt_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 1 ms time-base strobe, one cycle wide |
| early_valid_i | input | 1 | Discriminator reports a valid pair |
| row_i | input | 2 | Low-group index of the pair |
| col_i | input | 2 | High-group index of the pair |
| inhibit_i | input | 1 | Mask pairs in column 3 |
| oe_i | input | 1 | Code bus output enable |
| pdown_i | input | 1 | Power-down |
| code_o | output | 4 | Latched key code |
| code_oe_o | output | 1 | Pad driver enable for code_o |
| dv_o | output | 1 | Delayed valid flag |
| gt_o | output | 1 | Guard-time status |

## Verification
Registration and release fall on the clock edge that carries the last required strobe, and gt_o changes on that same edge. code_o follows LATCH_DLY edges after registration and dv_o follows FLAG_DLY edges after it. Power-down takes effect on the next edge. The bench's reference model schedules each of these results on the exact edge where it is due. The bench drives inputs one time unit after the rising edge and compares every output at the falling edge, so it checks each result in the first cycle it can appear. Directed checks also measure the cycle gap between the code update and the flag rise, and they sample each boundary case after its guard window has fully elapsed.

// File: rtl/tone_steer_pkg.sv
package tone_steer_pkg;

  localparam int unsigned IDX_W  = 2;
  localparam int unsigned CODE_W = 4;

  typedef enum logic [1:0] {
    ST_FREE = 2'd0,
    ST_ARM  = 2'd1,
    ST_LOCK = 2'd2,
    ST_DROP = 2'd3
  } steer_st_e;

  // Key code of a (row, col) pair over a 4x4 keypad.
  function automatic logic [CODE_W-1:0] pair_to_code(
    input logic [IDX_W-1:0] row,
    input logic [IDX_W-1:0] col
  );
    logic [CODE_W-1:0] res;
    if (col == 2'd3) begin
      res = CODE_W'(4'd13 + {2'b00, row});  // A..C = 13..15, D wraps to 0
    end else if (row != 2'd3) begin
      res = CODE_W'({row, 2'b00} - {2'b00, row} + {2'b00, col} + 4'd1);  // 3r+c+1
    end else begin
      case (col)
        2'd0:    res = 4'd11;  // *
        2'd1:    res = 4'd10;  // 0
        default: res = 4'd12;  // #
      endcase
    end
    return res;
  endfunction

endpackage

// File: rtl/pair_qualify.sv
module pair_qualify
  import tone_steer_pkg::*;
(
  input  logic              early_valid_i,
  input  logic [IDX_W-1:0]  row_i,
  input  logic [IDX_W-1:0]  col_i,
  input  logic              inhibit_i,
  output logic              qual_valid_o,
  output logic [CODE_W-1:0] pair_code_o
);

  logic masked;

  always_comb begin
    masked       = inhibit_i && (col_i == 2'd3);
    qual_valid_o = early_valid_i && !masked;
    pair_code_o  = pair_to_code(row_i, col_i);
  end

endmodule

// File: rtl/guard_steer.sv
module guard_steer
  import tone_steer_pkg::*;
#(
  parameter int unsigned PRESENT_TICKS = 30,
  parameter int unsigned ABSENT_TICKS  = 30
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic valid_i,
  input  logic pdown_i,
  output logic reg_o,
  output logic rel_o,
  output logic locked_o
);

  localparam int unsigned MAX_T = (PRESENT_TICKS > ABSENT_TICKS) ? PRESENT_TICKS : ABSENT_TICKS;
  localparam int unsigned CNT_W = $clog2(MAX_T + 1);
  localparam logic [CNT_W-1:0] P_LAST = CNT_W'(PRESENT_TICKS - 1);
  localparam logic [CNT_W-1:0] A_LAST = CNT_W'(ABSENT_TICKS - 1);

  steer_st_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             reg_d, rel_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    reg_d = 1'b0;
    rel_d = 1'b0;
    if (pdown_i) begin
      st_d  = ST_FREE;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        ST_FREE: begin
          if (valid_i) begin
            st_d  = ST_ARM;
            cnt_d = '0;
          end
        end
        ST_ARM: begin
          if (!valid_i) begin
            st_d  = ST_FREE;
            cnt_d = '0;
          end else if (tick_i) begin
            if (cnt_q == P_LAST) begin
              st_d  = ST_LOCK;
              cnt_d = '0;
              reg_d = 1'b1;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        ST_LOCK: begin
          if (!valid_i) begin
            st_d  = ST_DROP;
            cnt_d = '0;
          end
        end
        ST_DROP: begin
          if (valid_i) begin
            st_d  = ST_LOCK;  // dropout bridged
            cnt_d = '0;
          end else if (tick_i) begin
            if (cnt_q == A_LAST) begin
              st_d  = ST_FREE;
              cnt_d = '0;
              rel_d = 1'b1;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        default: begin
          st_d  = ST_FREE;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_FREE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  // reg_o/rel_o are strobes valid in the cycle the transition is taken
  assign reg_o    = reg_d;
  assign rel_o    = rel_d;
  assign locked_o = (st_q == ST_LOCK);

endmodule

// File: rtl/settle_pipe.sv
module settle_pipe #(
  parameter int unsigned LATCH_DLY = 4,
  parameter int unsigned FLAG_DLY  = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic clear_i,
  output logic latch_ld_o,
  output logic flag_set_o
);

  logic stage_q [FLAG_DLY];

  for (genvar i = 0; i < FLAG_DLY; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      stage_q[i] <= 1'b0;
        else if (clear_i) stage_q[i] <= 1'b0;
        else              stage_q[i] <= start_i;
      end
    end else begin : g_body
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      stage_q[i] <= 1'b0;
        else if (clear_i) stage_q[i] <= 1'b0;
        else              stage_q[i] <= stage_q[i-1];
      end
    end
  end

  // Stage k-1 is set k-1 edges after start; acting on it lands on edge k.
  assign latch_ld_o = stage_q[LATCH_DLY-1] && !clear_i;
  assign flag_set_o = stage_q[FLAG_DLY-1]  && !clear_i;

endmodule

// File: rtl/tone_digit_steer.sv
module tone_digit_steer
  import tone_steer_pkg::*;
#(
  parameter int unsigned PRESENT_TICKS = 30,
  parameter int unsigned ABSENT_TICKS  = 30,
  parameter int unsigned LATCH_DLY     = 4,
  parameter int unsigned FLAG_DLY      = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              early_valid_i,
  input  logic [IDX_W-1:0]  row_i,
  input  logic [IDX_W-1:0]  col_i,
  input  logic              inhibit_i,
  input  logic              oe_i,
  input  logic              pdown_i,
  output logic [CODE_W-1:0] code_o,
  output logic              code_oe_o,
  output logic              dv_o,
  output logic              gt_o
);

  logic              qual_valid;
  logic [CODE_W-1:0] pair_code;
  logic              reg_evt, rel_evt, locked;
  logic              latch_ld, flag_set, pipe_clr;
  logic [CODE_W-1:0] pend_q, latch_q;
  logic              dv_q;

  pair_qualify u_qual (
    .early_valid_i (early_valid_i),
    .row_i         (row_i),
    .col_i         (col_i),
    .inhibit_i     (inhibit_i),
    .qual_valid_o  (qual_valid),
    .pair_code_o   (pair_code)
  );

  guard_steer #(
    .PRESENT_TICKS (PRESENT_TICKS),
    .ABSENT_TICKS  (ABSENT_TICKS)
  ) u_guard (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .valid_i  (qual_valid),
    .pdown_i  (pdown_i),
    .reg_o    (reg_evt),
    .rel_o    (rel_evt),
    .locked_o (locked)
  );

  assign pipe_clr = pdown_i || rel_evt;

  settle_pipe #(
    .LATCH_DLY (LATCH_DLY),
    .FLAG_DLY  (FLAG_DLY)
  ) u_pipe (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (reg_evt),
    .clear_i    (pipe_clr),
    .latch_ld_o (latch_ld),
    .flag_set_o (flag_set)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= '0;
      latch_q <= '0;
    end else begin
      if (reg_evt)  pend_q  <= pair_code;
      if (latch_ld) latch_q <= pend_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       dv_q <= 1'b0;
    else if (pipe_clr) dv_q <= 1'b0;
    else if (flag_set) dv_q <= 1'b1;
  end

  assign code_o    = latch_q;
  assign code_oe_o = oe_i;
  assign dv_o      = dv_q;
  assign gt_o      = locked;

endmodule

// File: rtl/tone_digit_steer_chk.sv
module tone_digit_steer_chk #(
  parameter int unsigned LATCH_DLY = 4,
  parameter int unsigned FLAG_DLY  = 6
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       early_valid_i,
  input logic [1:0] col_i,
  input logic       inhibit_i,
  input logic       pdown_i,
  input logic [3:0] code_o,
  input logic       dv_o,
  input logic       gt_o
);

  // R7
  initial dly_order_chk: assert (FLAG_DLY > LATCH_DLY && LATCH_DLY > 0);

  // R7
  flag_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dv_o) |-> $stable(code_o));

  // R4
  flag_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dv_o) |-> !gt_o);

  // R10
  pdown_park_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pdown_i |=> (!dv_o && !gt_o && $stable(code_o)));

  // R9
  gt_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gt_o) |-> $past(early_valid_i));

  // R6
  inhibit_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inhibit_i && col_i == 2'd3) |=> !gt_o);

endmodule

bind tone_digit_steer tone_digit_steer_chk #(
  .LATCH_DLY (LATCH_DLY),
  .FLAG_DLY  (FLAG_DLY)
) u_chk (.*);

// File: tb/tb_tone_digit_steer.sv
module tb_tone_digit_steer;

  localparam int P_T  = 30;
  localparam int A_T  = 30;
  localparam int L_D  = 4;
  localparam int F_D  = 6;
  localparam int TDIV = 4;  // clocks per 1 ms strobe

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       ev = 1'b0;
  logic [1:0] row = '0, col = '0;
  logic       inh = 1'b0, oe = 1'b1, pdn = 1'b0;
  logic [3:0] code;
  logic       code_oe, dv, gt;

  int tests_run = 0;
  int tests_failed = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tone_digit_steer #(
    .PRESENT_TICKS (P_T), .ABSENT_TICKS (A_T), .LATCH_DLY (L_D), .FLAG_DLY (F_D)
  ) dut (
    .clk_i (clk), .rst_ni (rst_n), .tick_i (tick), .early_valid_i (ev),
    .row_i (row), .col_i (col), .inhibit_i (inh), .oe_i (oe), .pdown_i (pdn),
    .code_o (code), .code_oe_o (code_oe), .dv_o (dv), .gt_o (gt)
  );

  function automatic logic [3:0] key_code(int r, int c);
    string pad = "123A456B789C*0#D";
    byte k = pad[r*4 + c];
    if (k >= "1" && k <= "9") return 4'(k - "0");
    case (k)
      "0": return 4'd10;
      "*": return 4'd11;
      "#": return 4'd12;
      "A": return 4'd13;
      "B": return 4'd14;
      "C": return 4'd15;
      default: return 4'd0;
    endcase
  endfunction

  // Behavioural reference: phase, strobe count, scheduled events by cycle number
  int       m_ph = 0;  // 0 idle, 1 timing presence, 2 held, 3 timing absence
  int       m_cnt = 0;
  int       cyc = 0;
  int       lat_due = -1, flg_due = -1;
  logic [3:0] m_pend = '0, m_code = '0;
  bit       m_dv = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; lat_due = -1; flg_due = -1;
      m_pend = '0; m_code = '0; m_dv = 0; cyc = 0;
    end else begin
      bit q;
      cyc++;
      q = ev && !(inh && col == 2'd3);
      if (pdn) begin
        m_ph = 0; m_cnt = 0; m_dv = 0; lat_due = -1; flg_due = -1;
      end else begin
        if (lat_due == cyc) m_code = m_pend;
        if (flg_due == cyc) m_dv = 1;
        case (m_ph)
          0: if (q) begin m_ph = 1; m_cnt = 0; end
          1: if (!q) m_ph = 0;
             else if (tick) begin
               m_cnt++;
               if (m_cnt == P_T) begin
                 m_ph = 2; m_pend = key_code(row, col);
                 lat_due = cyc + L_D; flg_due = cyc + F_D;
               end
             end
          2: if (!q) begin m_ph = 3; m_cnt = 0; end
          default: if (q) m_ph = 2;
             else if (tick) begin
               m_cnt++;
               if (m_cnt == A_T) begin
                 m_ph = 0; m_dv = 0; lat_due = -1; flg_due = -1;
               end
             end
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      tests_run++;
      if (code !== m_code || dv !== m_dv || gt !== (m_ph == 2) || code_oe !== oe) begin
        tests_failed++;
        $display("FAIL R5/R7/R9/R8 model cyc %0d: code=%b dv=%b gt=%b oe=%b expected code=%b dv=%b gt=%b oe=%b",
                 cyc, code, dv, gt, code_oe, m_code, m_dv, m_ph == 2, oe);
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    @(negedge clk);
    tests_run++;
    if (act !== exp) begin
      tests_failed++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic ms(int n);
    repeat (n * TDIV) @(posedge clk);
    #1;
  endtask

  task automatic tone(int r, int c, int dur);
    row = 2'(r); col = 2'(c); ev = 1'b1;
    ms(dur);
  endtask

  task automatic quiet(int dur);
    ev = 1'b0;
    ms(dur);
  endtask

  task automatic finish_run();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  endtask

  initial begin
    @(posedge rst_n);
    forever begin
      repeat (TDIV - 1) @(posedge clk);
      #1 tick = 1'b1;
      @(posedge clk);
      #1 tick = 1'b0;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests_run++;
    tests_failed++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    int gap;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R11 reset state
    chk("R11 code", code, 0);
    chk("R11 dv", dv, 0);
    chk("R11 gt", gt, 0);

    // R1 short burst rejected
    @(posedge clk); #1;
    tone(1, 1, 20);
    quiet(50);
    chk("R1 code", code, 0);
    chk("R1 dv", dv, 0);

    // R2/R7 registration and code-to-flag spacing
    row = 2'd1; col = 2'd1; ev = 1'b1;
    begin
      int w = 0;
      while (code == 4'd0 && w < 400) begin @(negedge clk); w++; end
      gap = 0;
      while (!dv && gap < 50) begin @(negedge clk); gap++; end
    end
    chk("R7 flag after code", gap, F_D - L_D);
    ms(10);
    chk("R2 code 5", code, 4'b0101);
    chk("R9 gt held", gt, 1);

    // R3 dropout bridged, other pair not taken
    ev = 1'b0;
    ms(10);
    chk("R3 dv kept", dv, 1);
    chk("R9 gt in dropout", gt, 0);
    tone(0, 0, 40);
    chk("R3 no reload", code, 4'b0101);
    quiet(45);
    chk("R4 released", dv, 0);

    // R5 full table
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) begin
        tone(r, c, 40);
        chk($sformatf("R5 key r%0d c%0d", r, c), code, key_code(r, c));
        quiet(40);
      end

    // R6 inhibit
    inh = 1'b1;
    tone(1, 3, 45);
    chk("R6 masked code", code, 4'b0000);
    chk("R6 masked dv", dv, 0);
    tone(1, 2, 45);
    chk("R6 other column", code, 4'b0110);
    quiet(45);
    inh = 1'b0;

    // R8 output enable
    oe = 1'b0;
    chk("R8 oe low", code_oe, 0);
    chk("R8 latch kept", code, 4'b0110);
    oe = 1'b1;
    chk("R8 oe high", code_oe, 1);
    chk("R8 code back", code, 4'b0110);

    // R10 power-down
    tone(2, 2, 45);
    chk("R10 pre", dv, 1);
    pdn = 1'b1;
    repeat (5) @(posedge clk);
    #1;
    chk("R10 dv", dv, 0);
    chk("R10 gt", gt, 0);
    chk("R10 code", code, 4'b1001);
    pdn = 1'b0;
    quiet(45);
    tone(0, 2, 20);
    pdn = 1'b1;
    repeat (2) @(posedge clk);
    #1 pdn = 1'b0;
    ms(20);
    quiet(45);
    chk("R10 timer cleared", code, 4'b1001);
    chk("R10 dv idle", dv, 0);

    finish_run();
  end

endmodule